// File: doc/BRIEF.md
# Stepped Gain Wiper Controller with Overload Protection

This block owns the wiper position of a 100-position digital potentiometer that sets detector gain. The potentiometer itself only understands single up or down step pulses and a "store" command, so the controller keeps its own copy of the position, turns requests into step pulses one at a time, and never issues a pulse that would move the wiper past either end.

Requests come from three places. A user can nudge the gain up or down one step per request. A start-up command sends the wiper to mid-scale, one step per clock. An optional protection mode watches each new light reading. When a reading rises above a programmable trip level, it takes gain away one step per reading until the reading settles at least about 5% below the trip level. Protection only ever lowers gain. While a reduction is under way, every upward request is refused. Separately, each reading is compared with a programmable full-scale code to raise an overrange flag.

Top module: `gain_wiper_ctrl`

## Requirements
- R1: The position `wiper_pos` always lies in 0..99.
- R2: After reset, `wiper_pos` is 99, no step or store pulse is active, and `overrange` is 0.
- R3: When `cmd_mid` is asserted in a cycle, the wiper then moves one step per clock toward position 50 and stops there. Downward moves happen whenever needed. Upward moves are held off while a reduction is in progress.
- R4: When no reduction, slew or protection step is active, `cmd_up` alone raises the position by one and `cmd_down` alone lowers it by one. Both asserted together have no effect. A cycle with `cmd_mid` asserted takes no user step.
- R5: `step_up` (`step_down`) is high for exactly the cycle in which `wiper_pos` shows one more (one less) than in the previous cycle. They are never both high, and the position changes at no other time.
- R6: No step is taken up from 99 or down from 0. A request at a limit leaves the position unchanged and pulses nothing.
- R7: With `prot_mode` high, a strobe whose reading is above `trip_level` starts a reduction and requests one down step. During a reduction, every strobe whose reading is above trip − ⌊trip/20⌋ requests one down step. A strobe with a reading at or below that margin ends the reduction. At most one step is taken per strobe, and a protection step takes priority over slew and user steps.
- R8: While a reduction is in progress, and in a cycle with a protection step, no upward step occurs. User up requests are ignored in those cycles.
- R9: On each `rdg_valid` strobe, `overrange` becomes (reading > `full_scale`), visible from the next cycle. Between strobes it holds its value.
- R10: `cmd_store` produces a one-cycle `store_pulse` in the next cycle.
- R11: Dropping `prot_mode` ends any reduction in progress, so user up requests are accepted again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdg_valid | input | 1 | New light reading strobe |
| rdg_value | input | 16 | Light reading code |
| trip_level | input | 16 | Protection trip code |
| full_scale | input | 16 | Overrange threshold code |
| prot_mode | input | 1 | 1 = protection mode enabled |
| cmd_up | input | 1 | User request: one step up |
| cmd_down | input | 1 | User request: one step down |
| cmd_mid | input | 1 | Start-up request: slew to mid-scale |
| cmd_store | input | 1 | Save current position as power-up setting |
| step_up | output | 1 | Wiper up step pulse |
| step_down | output | 1 | Wiper down step pulse |
| wiper_pos | output | 7 | Tracked wiper position |
| store_pulse | output | 1 | Store command pulse to potentiometer |
| overrange | output | 1 | Last reading exceeded full scale |

## Verification
A wrong position count shows on `wiper_pos` in the very cycle after the faulty edge, so a per-clock comparison with a behavioural model catches it at once. A stale reduction flag is hidden until a user up request arrives or a strobe lands in the band between margin and trip. The stimulus therefore places strobes in that band and asserts `cmd_up` during reductions and right after protection is switched off. A broken slew direction or end test shows up as a run of steps that overshoots or stops short of 50.

// File: rtl/gwc_pkg.sv
package gwc_pkg;

  // protection release threshold: trip less one twentieth (about 5%)
  function automatic logic [31:0] release_level(input logic [31:0] trip);
    return trip - (trip / 32'd20);
  endfunction

  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2
  } move_e;

endpackage

// File: rtl/gwc_protect.sv
module gwc_protect #(
  parameter int RDG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdg_valid,
  input  logic [RDG_W-1:0] rdg_value,
  input  logic [RDG_W-1:0] trip_level,
  input  logic [RDG_W-1:0] full_scale,
  input  logic             prot_mode,
  output logic             prot_req,
  output logic             reducing,
  output logic             overrange
);
  import gwc_pkg::*;

  logic [RDG_W-1:0] margin;
  logic             above_trip;
  logic             above_margin;
  logic             red_q;
  logic             ovr_q;

  assign margin       = RDG_W'(release_level(32'(trip_level)));
  assign above_trip   = rdg_value > trip_level;
  assign above_margin = rdg_value > margin;
  assign prot_req     = prot_mode && rdg_valid && (above_trip || (red_q && above_margin));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      red_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (!prot_mode)                    red_q <= 1'b0;
      else if (rdg_valid && above_trip)  red_q <= 1'b1;
      else if (rdg_valid && !above_margin) red_q <= 1'b0;
      if (rdg_valid) ovr_q <= rdg_value > full_scale;
    end
  end

  assign reducing  = red_q;
  assign overrange = ovr_q;

  // R11: leaving protection mode always ends the reduction
  assert_prot_off_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_mode |=> !reducing);
  // R9: flag holds between strobes
  assert_ovr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdg_valid |=> $stable(overrange));
  // R7: a reduction can only begin on a strobe in protection mode
  assert_red_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reducing && !(prot_mode && rdg_valid)) |=> !reducing);

endmodule

// File: rtl/gwc_arbiter.sv
module gwc_arbiter #(
  parameter int POS_W = 7,
  parameter int MAX_POS = 99,
  parameter int MID_POS = 50
) (
  input  logic [POS_W-1:0] pos,
  input  logic             prot_req,
  input  logic             reducing,
  input  logic             slewing,
  input  logic             cmd_mid,
  input  logic             cmd_up,
  input  logic             cmd_down,
  output gwc_pkg::move_e   move
);
  import gwc_pkg::*;

  move_e want;
  logic  at_top;
  logic  at_bot;

  assign at_top = pos >= POS_W'(MAX_POS);
  assign at_bot = pos == '0;

  always_comb begin
    want = MV_NONE;
    if (prot_req) begin
      want = MV_DOWN;
    end else if (slewing) begin
      if (pos > POS_W'(MID_POS))                    want = MV_DOWN;
      else if (pos < POS_W'(MID_POS) && !reducing)  want = MV_UP;
    end else if (!cmd_mid) begin
      if (cmd_down && !cmd_up)                      want = MV_DOWN;
      else if (cmd_up && !cmd_down && !reducing)    want = MV_UP;
    end
  end

  always_comb begin
    move = want;
    if (want == MV_UP && at_top)   move = MV_NONE;
    if (want == MV_DOWN && at_bot) move = MV_NONE;
  end

  // R8: no upward choice while protection is active or requesting
  always_comb begin
    if (reducing || prot_req)
      assert_no_up_when_reducing_R8: assert (move != MV_UP);
  end

endmodule

// File: rtl/gwc_wiper.sv
module gwc_wiper #(
  parameter int POS_W = 7,
  parameter int MAX_POS = 99,
  parameter int MID_POS = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gwc_pkg::move_e   move,
  input  logic             cmd_mid,
  input  logic             cmd_store,
  output logic [POS_W-1:0] pos,
  output logic             slewing,
  output logic             step_up,
  output logic             step_down,
  output logic             store_pulse
);
  import gwc_pkg::*;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic             slew_q;
  logic             up_q;
  logic             dn_q;
  logic             st_q;

  always_comb begin
    pos_d = pos_q;
    if (move == MV_UP)   pos_d = pos_q + 1'b1;
    if (move == MV_DOWN) pos_d = pos_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= POS_W'(MAX_POS);
      slew_q <= 1'b0;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      slew_q <= cmd_mid || (slew_q && pos_d != POS_W'(MID_POS));
      up_q   <= move == MV_UP;
      dn_q   <= move == MV_DOWN;
      st_q   <= cmd_store;
    end
  end

  assign pos         = pos_q;
  assign slewing     = slew_q;
  assign step_up     = up_q;
  assign step_down   = dn_q;
  assign store_pulse = st_q;

  assert_pos_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_W'(MAX_POS));
  assert_step_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_down));
  assert_up_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (move == MV_UP) |=> (step_up && pos == $past(pos) + 1'b1));
  assert_down_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (move == MV_DOWN) |=> (step_down && pos == $past(pos) - 1'b1));
  assert_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (move == MV_NONE) |=> ($stable(pos) && !step_up && !step_down));
  assert_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_store |=> store_pulse);

endmodule

// File: rtl/gain_wiper_ctrl.sv
module gain_wiper_ctrl #(
  parameter int RDG_W = 16,
  parameter int POSITIONS = 100,
  localparam int POS_W = $clog2(POSITIONS),
  localparam int MAX_POS = POSITIONS - 1,
  localparam int MID_POS = POSITIONS / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdg_valid,
  input  logic [RDG_W-1:0] rdg_value,
  input  logic [RDG_W-1:0] trip_level,
  input  logic [RDG_W-1:0] full_scale,
  input  logic             prot_mode,
  input  logic             cmd_up,
  input  logic             cmd_down,
  input  logic             cmd_mid,
  input  logic             cmd_store,
  output logic             step_up,
  output logic             step_down,
  output logic [POS_W-1:0] wiper_pos,
  output logic             store_pulse,
  output logic             overrange
);
  import gwc_pkg::*;

  logic  prot_req;
  logic  reducing;
  logic  slewing;
  move_e move;

  gwc_protect #(.RDG_W(RDG_W)) u_protect (
    .clk(clk), .rst_n(rst_n), .rdg_valid(rdg_valid), .rdg_value(rdg_value),
    .trip_level(trip_level), .full_scale(full_scale), .prot_mode(prot_mode),
    .prot_req(prot_req), .reducing(reducing), .overrange(overrange)
  );

  gwc_arbiter #(.POS_W(POS_W), .MAX_POS(MAX_POS), .MID_POS(MID_POS)) u_arbiter (
    .pos(wiper_pos), .prot_req(prot_req), .reducing(reducing), .slewing(slewing),
    .cmd_mid(cmd_mid), .cmd_up(cmd_up), .cmd_down(cmd_down), .move(move)
  );

  gwc_wiper #(.POS_W(POS_W), .MAX_POS(MAX_POS), .MID_POS(MID_POS)) u_wiper (
    .clk(clk), .rst_n(rst_n), .move(move), .cmd_mid(cmd_mid), .cmd_store(cmd_store),
    .pos(wiper_pos), .slewing(slewing), .step_up(step_up), .step_down(step_down),
    .store_pulse(store_pulse)
  );

  // R7: a reading above trip in protection mode takes a step down unless at 0
  assert_trip_steps_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_mode && rdg_valid && rdg_value > trip_level && wiper_pos != '0) |=> step_down);
  // R6: never a step beyond the ends
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_pos == POS_W'(MAX_POS)) |=> !step_up || $past(wiper_pos) != POS_W'(MAX_POS));

endmodule

// File: tb/tb_gain_wiper_ctrl.sv
module tb_gain_wiper_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rdg_valid = 1'b0;
  logic [15:0] rdg_value = '0;
  logic [15:0] trip_level = 16'd1000;
  logic [15:0] full_scale = 16'd4000;
  logic        prot_mode = 1'b0;
  logic        cmd_up = 1'b0, cmd_down = 1'b0, cmd_mid = 1'b0, cmd_store = 1'b0;
  logic        step_up, step_down, store_pulse, overrange;
  logic [6:0]  wiper_pos;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gain_wiper_ctrl dut (.*);

  // behavioural reference
  int m_pos = 99, m_red = 0, m_slew = 0, m_su = 0, m_sd = 0, m_ov = 0, m_st = 0;

  always @(posedge clk) begin
    int dir, marg;
    bit preq;
    if (!rst_n) begin
      m_pos = 99; m_red = 0; m_slew = 0; m_su = 0; m_sd = 0; m_ov = 0; m_st = 0;
    end else begin
      marg = int'(trip_level) - int'(trip_level) / 20;
      preq = prot_mode && rdg_valid &&
             (int'(rdg_value) > int'(trip_level) || (m_red != 0 && int'(rdg_value) > marg));
      dir = 0;
      if (preq) dir = -1;
      else if (m_slew != 0) begin
        if (m_pos > 50) dir = -1;
        else if (m_pos < 50 && m_red == 0) dir = 1;
      end else if (!cmd_mid && cmd_up != cmd_down) begin
        if (cmd_down) dir = -1;
        else if (m_red == 0) dir = 1;
      end
      if (dir == 1 && m_pos == 99) dir = 0;
      if (dir == -1 && m_pos == 0) dir = 0;
      m_pos = m_pos + dir;
      m_su = (dir == 1); m_sd = (dir == -1);
      m_slew = (cmd_mid || (m_slew != 0 && m_pos != 50)) ? 1 : 0;
      if (!prot_mode) m_red = 0;
      else if (rdg_valid && int'(rdg_value) > int'(trip_level)) m_red = 1;
      else if (rdg_valid && int'(rdg_value) <= marg) m_red = 0;
      if (rdg_valid) m_ov = (rdg_value > full_scale);
      m_st = cmd_store;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R1/R3/R4/R6/R7/R8/R11 wiper_pos", int'(wiper_pos), m_pos);
    chk("R5 step_up", int'(step_up), m_su);
    chk("R5 step_down", int'(step_down), m_sd);
    chk("R9 overrange", int'(overrange), m_ov);
    chk("R10 store_pulse", int'(store_pulse), m_st);
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input int v);
    rdg_value = 16'(v); rdg_valid = 1'b1; cyc(); rdg_valid = 1'b0; cyc(2);
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk("R2 reset pos", int'(wiper_pos), 99);
    chk("R2 reset overrange", int'(overrange), 0);
    // R6: up at top is ignored
    cmd_up = 1; cyc(3); cmd_up = 0;
    chk("R6 top hold", int'(wiper_pos), 99);
    // R4: downs, both together
    cmd_down = 1; cyc(5); cmd_down = 0;
    chk("R4 down five", int'(wiper_pos), 94);
    cmd_up = 1; cmd_down = 1; cyc(3); cmd_up = 0; cmd_down = 0;
    chk("R4 both ignored", int'(wiper_pos), 94);
    // R10
    cmd_store = 1; cyc(); cmd_store = 0; cyc(2);
    // R3: slew from 94 down to 50
    cmd_mid = 1; cyc(); cmd_mid = 0; cyc(60);
    chk("R3 mid from above", int'(wiper_pos), 50);
    cmd_down = 1; cyc(60); cmd_down = 0;
    chk("R6 bottom hold", int'(wiper_pos), 0);
    cmd_mid = 1; cyc(); cmd_mid = 0; cyc(60);
    chk("R3 mid from below", int'(wiper_pos), 50);
    // R7/R8: protection, trip 1000, margin 950
    prot_mode = 1;
    strobe(990);
    chk("R7 band without reduction", int'(wiper_pos), 50);
    strobe(1200);
    chk("R7 first step", int'(wiper_pos), 49);
    cmd_up = 1; cyc(4); cmd_up = 0;
    chk("R8 up ignored", int'(wiper_pos), 49);
    strobe(980); strobe(951);
    chk("R7 margin steps", int'(wiper_pos), 47);
    strobe(950);
    chk("R7 released", int'(wiper_pos), 47);
    cmd_up = 1; cyc(); cmd_up = 0; cyc();
    chk("R8 up after release", int'(wiper_pos), 48);
    strobe(5000);
    // R9: overrange set by strobe above full scale
    chk("R9 overrange set", int'(overrange), 1);
    prot_mode = 0; cyc();
    cmd_up = 1; cyc(); cmd_up = 0; cyc();
    chk("R11 up after mode off", int'(wiper_pos), 48);
    strobe(100);
    chk("R9 overrange clear", int'(overrange), 0);
    // mixed pseudo-random stimulus
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cmd_up    = lfsr[0] & lfsr[3];
        cmd_down  = lfsr[1] & lfsr[4];
        cmd_mid   = (lfsr[7:2] == 6'd0);
        cmd_store = lfsr[8] & lfsr[9] & lfsr[10];
        rdg_valid = lfsr[11] | lfsr[5];
        rdg_value = 16'd850 + 16'(lfsr[15:9]) * 16'd3;
        if (lfsr[12:6] == 7'd0) prot_mode = ~prot_mode;
        if (i == 2000) rst_n = 1'b0;
        if (i == 2003) rst_n = 1'b1;
        cyc();
      end
    end
    cmd_up = 0; cmd_down = 0; cmd_mid = 0; cmd_store = 0; rdg_valid = 0;
    cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule